// File: doc/BRIEF.md
# Sleep Entry and Exit Controller

This block sequences a synchronous memory into and out of a low-power sleep state. The sleep request arrives asynchronously. It passes through a flop synchroniser first. A small state machine then walks through fixed-length entry, sleep, exit and recovery phases. While the array is asleep, the block raises a power-down enable that holds the array contents.

Accesses are granted only while the block is fully awake and no synchronised request is pending. When sleep begins, the block pulses a discard signal so that the access path throws away any operation still in flight. Any access attempt made while the block is not ready is refused. Such an attempt also sets a sticky violation flag that only reset clears. The memory controller that drives the block reads that flag to find protocol errors in its own sequencing.

Top module: `sleep_ctrl`

## Requirements
- R1: After synchronous active-low reset, ready is 1, pd_en is 0, flush is 0 and viol is 0.
- R2: The request passes through two synchroniser flops before use. If the request is first seen high at clock edge k, ready is still 1 after edge k+1 and falls after edge k+2.
- R3: Entry lasts exactly two cycles. flush is high only in the first of them. pd_en rises after the second, i.e. after edge k+4 in the timing of R2.
- R4: If the request is first seen low at edge j while asleep, pd_en falls after edge j+2. Two exit cycles and two recovery cycles follow, and ready rises after edge j+6.
- R5: acc_grant equals acc_req while ready is 1 and the synchronised request is low. At every other time acc_grant is 0.
- R6: acc_req while ready is 0, or while the synchronised request is high, is not granted and sets viol from the next edge.
- R7: viol stays 1 until the next reset.
- R8: A request withdrawn during entry does not abort the entry. pd_en is high for at least one cycle, and then exit and recovery run in full.
- R9: ready is 1 only in the awake state, and pd_en is 1 only in the asleep state. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req_a | input | 1 | Asynchronous sleep request, active high |
| acc_req | input | 1 | Access attempt: chip selected with an address strobe |
| ready | output | 1 | Block is awake and may accept accesses |
| pd_en | output | 1 | Power-down enable for the array |
| flush | output | 1 | One-cycle pulse that discards pending accesses on entry |
| acc_grant | output | 1 | The current access attempt is accepted |
| viol | output | 1 | Sticky protocol-violation flag |

## Verification
A state machine stuck in, or skipping, a phase shows up at once as a shift in the edge on which ready or pd_en changes. A cycle-accurate model in the bench catches this on the same cycle. A wrong synchroniser depth moves every one of those edges by one cycle. A flag that is not held shows as viol falling without reset on the following cycle. A gate that lets accesses through early shows as acc_grant being high while ready is low.

// File: rtl/sleep_pkg.sv
// Package: shared state encoding for the sleep controller.
// Assumes: all submodules of sleep_ctrl import this package.
package sleep_pkg;

    typedef enum logic [2:0] {
        ST_AWAKE    = 3'd0,
        ST_ENTERING = 3'd1,
        ST_ASLEEP   = 3'd2,
        ST_EXITING  = 3'd3,
        ST_RECOVERY = 3'd4
    } slp_state_t;

endpackage

// File: rtl/sleep_sync.sv
// Module: multi-flop synchroniser for the asynchronous sleep request.
// Assumes: STAGES >= 2; the flops clear to 0 on synchronous reset.
module sleep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] stg;

    // Each stage samples the previous one; stage 0 samples the raw input.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= 1'b0;
                else        stg[0] <= d_async;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= 1'b0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/sleep_fsm.sv
// Module: phase sequencer (awake, entering, asleep, exiting, recovery).
// Assumes: req_s is already synchronised; every phase length is >= 1 cycle.
module sleep_fsm
    import sleep_pkg::*;
#(
    parameter int ENTER_CYC = 2,
    parameter int EXIT_CYC  = 2,
    parameter int RECOV_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_s,
    output slp_state_t state,
    output logic       ready,
    output logic       pd_en,
    output logic       flush
);

    localparam int MAX_A = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
    localparam int MAX_C = (MAX_A > RECOV_CYC) ? MAX_A : RECOV_CYC;
    localparam int CNT_W = (MAX_C > 1) ? $clog2(MAX_C) : 1;

    slp_state_t       nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             last;

    assign last = (cnt == '0);

    // Next-state and phase-counter selection.
    always_comb begin
        nxt     = state;
        cnt_nxt = last ? cnt : cnt - 1'b1;
        case (state)
            ST_AWAKE: if (req_s) begin
                nxt     = ST_ENTERING;
                cnt_nxt = CNT_W'(ENTER_CYC - 1);
            end
            ST_ENTERING: if (last) nxt = ST_ASLEEP;
            ST_ASLEEP: if (!req_s) begin
                nxt     = ST_EXITING;
                cnt_nxt = CNT_W'(EXIT_CYC - 1);
            end
            ST_EXITING: if (last) begin
                nxt     = ST_RECOVERY;
                cnt_nxt = CNT_W'(RECOV_CYC - 1);
            end
            ST_RECOVERY: if (last) nxt = ST_AWAKE;
            default: nxt = ST_AWAKE;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_AWAKE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    assign ready = (state == ST_AWAKE);
    assign pd_en = (state == ST_ASLEEP);
    assign flush = (state == ST_ENTERING) && (cnt == CNT_W'(ENTER_CYC - 1));

    // R3: power-down is only reached through the entry phase.
    a_r3_pd_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_en) |-> $past(state) == ST_ENTERING);

    // R4: leaving power-down always goes into the exit phase.
    a_r4_exit_after_pd: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_en) |-> state == ST_EXITING);

    // R4: ready returns only at the end of recovery.
    a_r4_ready_after_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(state) == ST_RECOVERY);

endmodule

// File: rtl/sleep_guard.sv
// Module: access gate and sticky violation flag.
// Assumes: ready marks the awake phase; req_s is the synchronised request.
module sleep_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_req,
    input  logic ready,
    input  logic req_s,
    output logic acc_grant,
    output logic viol
);

    logic bad_acc;

    assign bad_acc   = acc_req && (!ready || req_s);
    assign acc_grant = acc_req && ready && !req_s;

    // Latch any access attempt outside the open window until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) viol <= 1'b0;
        else        viol <= viol | bad_acc;
    end

    // R5: no grant outside the awake phase.
    a_r5_grant_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        acc_grant |-> ready);

    // R6: a refused access raises the flag next cycle.
    a_r6_bad_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !ready) |=> viol);

    // R7: the flag never clears without reset.
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> viol);

endmodule

// File: rtl/sleep_ctrl.sv
// Module: top of the sleep controller; wires synchroniser, sequencer, guard.
// Assumes: sleep_req_a may change at any time relative to clk.
module sleep_ctrl
    import sleep_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ENTER_CYC   = 2,
    parameter int EXIT_CYC    = 2,
    parameter int RECOV_CYC   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req_a,
    input  logic acc_req,
    output logic ready,
    output logic pd_en,
    output logic flush,
    output logic acc_grant,
    output logic viol
);

    logic       req_s;
    slp_state_t state;

    sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (sleep_req_a),
        .q_sync  (req_s)
    );

    sleep_fsm #(
        .ENTER_CYC (ENTER_CYC),
        .EXIT_CYC  (EXIT_CYC),
        .RECOV_CYC (RECOV_CYC)
    ) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .req_s (req_s),
        .state (state),
        .ready (ready),
        .pd_en (pd_en),
        .flush (flush)
    );

    sleep_guard u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_req   (acc_req),
        .ready     (ready),
        .req_s     (req_s),
        .acc_grant (acc_grant),
        .viol      (viol)
    );

    // R9: awake and powered-down never overlap.
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && pd_en));

    // R3: the discard pulse never coincides with an open access window.
    a_r3_flush_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !ready);

endmodule

// File: tb/test_sleep_ctrl.sv
`timescale 1ns/1ps
module test_sleep_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic acc = 1'b0;
    logic ready, pd_en, flush, acc_grant, viol;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    bit model_on = 1'b0;

    always #5 clk = ~clk;

    sleep_ctrl i_sleep_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req_a(req), .acc_req(acc),
        .ready(ready), .pd_en(pd_en), .flush(flush),
        .acc_grant(acc_grant), .viol(viol)
    );

    // Reference model built from the requirements (phases: 0 awake,
    // 1 entering, 2 asleep, 3 exiting, 4 recovery).
    logic m_s1 = 0, m_s2 = 0, m_viol = 0;
    int   m_ph = 0, m_left = 0, m_age = 0;

    function automatic logic exp_ready(int ph);
        return ph == 0;
    endfunction
    function automatic logic exp_pd(int ph);
        return ph == 2;
    endfunction
    function automatic logic exp_flush(int ph, int age);
        return (ph == 1) && (age == 0);
    endfunction
    function automatic logic exp_grant(int ph, logic s2, logic a);
        return a && (ph == 0) && !s2;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_viol <= 0; m_ph <= 0; m_left <= 0; m_age <= 0;
        end else begin
            m_s1 <= req;
            m_s2 <= m_s1;
            if (acc && (m_ph != 0 || m_s2)) m_viol <= 1'b1;
            m_age <= m_age + 1;
            case (m_ph)
                0: if (m_s2) begin m_ph <= 1; m_left <= 2; m_age <= 0; end
                1: if (m_left == 1) begin m_ph <= 2; m_age <= 0; end
                   else m_left <= m_left - 1;
                2: if (!m_s2) begin m_ph <= 3; m_left <= 2; m_age <= 0; end
                3: if (m_left == 1) begin m_ph <= 4; m_left <= 2; m_age <= 0; end
                   else m_left <= m_left - 1;
                default: if (m_left == 1) begin m_ph <= 0; m_age <= 0; end
                   else m_left <= m_left - 1;
            endcase
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model, mid-cycle.
    always @(negedge clk) begin
        if (model_on && rst_n && !done) begin
            chk("R9 ready",     ready,     exp_ready(m_ph));
            chk("R3 pd_en",     pd_en,     exp_pd(m_ph));
            chk("R3 flush",     flush,     exp_flush(m_ph, m_age));
            chk("R5 acc_grant", acc_grant, exp_grant(m_ph, m_s2, acc));
            chk("R6 viol",      viol,      m_viol);
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int pd_cycles;
        void'($urandom(32'd1234));
        tick(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 ready", ready, 1'b1);
        chk("R1 pd_en", pd_en, 1'b0);
        chk("R1 flush", flush, 1'b0);
        chk("R1 viol",  viol,  1'b0);

        // R2/R3: request seen at edge k
        req = 1'b1;
        tick(2);
        chk("R2 ready held two edges", ready, 1'b1);
        tick(1);
        chk("R2 ready falls at k+2", ready, 1'b0);
        chk("R3 flush first entry cycle", flush, 1'b1);
        tick(1);
        chk("R3 flush one cycle only", flush, 1'b0);
        chk("R3 pd_en low in entry", pd_en, 1'b0);
        tick(1);
        chk("R3 pd_en high at k+4", pd_en, 1'b1);
        tick(3);
        chk("R3 pd_en held asleep", pd_en, 1'b1);

        // R4: exit timing
        req = 1'b0;
        tick(2);
        chk("R4 pd_en held to j+1", pd_en, 1'b1);
        tick(1);
        chk("R4 pd_en falls at j+2", pd_en, 1'b0);
        tick(3);
        chk("R4 ready low at j+5", ready, 1'b0);
        tick(1);
        chk("R4 ready rises at j+6", ready, 1'b1);
        chk("R6 no violation yet", viol, 1'b0);

        // R8: one-cycle request pulse still completes a full cycle
        req = 1'b1;
        tick(1);
        req = 1'b0;
        pd_cycles = 0;
        for (int i = 0; i < 14; i++) begin
            tick(1);
            if (pd_en) pd_cycles++;
        end
        chk("R8 asleep at least one cycle", pd_cycles >= 1, 1'b1);
        chk("R8 back awake", ready, 1'b1);

        // R5/R6/R7: access during sleep refused and latched
        acc = 1'b1;
        @(negedge clk);
        chk("R5 grant when awake", acc_grant, 1'b1);
        acc = 1'b0;
        req = 1'b1;
        tick(5);
        acc = 1'b1;
        #1;
        chk("R6 no grant asleep", acc_grant, 1'b0);
        tick(1);
        acc = 1'b0;
        chk("R6 violation set", viol, 1'b1);
        req = 1'b0;
        tick(10);
        chk("R7 violation sticky", viol, 1'b1);

        // Random phase checked against the model
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 viol cleared by reset", viol, 1'b0);
        model_on = 1'b1;
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(0, 11) == 0) req = ~req;
            acc = ($urandom_range(0, 2) == 0);
            if (c == 2000) rst_n = 1'b0;
            if (c == 2002) rst_n = 1'b1;
            @(negedge clk);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule